// File: doc/BRIEF.md
# Programmable Serial Input Bit-Delay Sampler

This block resamples up to eight serial input lines with a clock running at four times the bit rate. Every line is captured into a sample history on each edge of that clock. Once per bit period, marked by a one-cycle strobe, the block picks one sample from each line's history and emits it as the realigned bit for that line. Where that sample sits inside the bit window is set by a 5-bit field, one field per line, held in a small register bank that is written through a simple write port.

The same field is decoded in one of two ways, chosen by a global mode input. With the mode low, the field is a single delay in quarter-bit steps added to a fixed sampling point three quarters into the bit. With the mode high, the two low field bits choose a sampling phase from the first to the fourth quarter of the bit, and the three high bits add a whole-bit delay of zero to seven bits. The register bank is 16 bits wide per line. Only the field is stored and the other bits always read back as zero.

All timing is counted in edges of the oversampling clock. The selection looks back over a fixed window: the reference start of the bit emitted at a strobe edge lies 36 clock edges (nine bit periods) before that strobe edge. A quarter-bit delay D picks the input sample captured D edges after that reference, which is the sample captured 36 − D edges before the strobe edge. The strobe is expected once every four clock edges.

Top module: `bit_delay_sampler`

## Requirements
- R1: After reset every register reads 0, `dout` is all zeros and `dout_valid` is 0.
- R2: `rd_data` returns the stored 5-bit field of line `rd_addr` in bits 4:0 and 0 in bits 15:5, whatever was written to those upper bits.
- R3: With `mode_hi` = 0 and field F, the delay is D = 3 + F quarter-bits. The bit emitted for that line at a strobe edge is the input sample captured 36 − D edges before that strobe edge. Samples from before reset count as 0.
- R4: With `mode_hi` = 0, F = 19 gives D = 22, which is the 3/4 default point plus 4 3/4 bits.
- R5: With `mode_hi` = 1, the delay is D = (F[1:0] + 1) + 4·F[4:2] quarter-bits, and the sample is chosen by the same rule as in R3.
- R6: With `mode_hi` = 1, F[1:0] = 00 samples at the 1/4 point (D = 1 for F = 0) and 11 at the 4/4 point (D = 4 for F = 3). F = 31 gives D = 32.
- R7: `dout` changes, and `dout_valid` is 1, only in the cycle that follows a clock edge at which `bit_strobe` was 1. In every other cycle `dout` holds and `dout_valid` is 0.
- R8: A write changes only the addressed line's field. The new value is first used at the first strobe edge after the write edge; a strobe at the write edge itself still uses the old value.
- R9: `mode_hi` is global and is sampled at each strobe edge, so changing it between strobes changes the decoding of every line from the next strobe on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, four edges per bit period |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | One-cycle pulse marking each bit boundary |
| din | input | 8 | Serial input lines, one bit per line |
| mode_hi | input | 1 | Field decoding: 0 = combined delay, 1 = phase plus whole bits |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Line whose register is written |
| wr_data | input | 16 | Write data; only bits 4:0 are kept |
| rd_addr | input | 3 | Line whose register is read |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| dout | output | 8 | Realigned bits, one per line |
| dout_valid | output | 1 | High in the cycle a new set of bits is presented |

## Verification
The realigned bits and `dout_valid` come out of one register stage, so they are due in the cycle after the strobe edge. The bench samples them at the falling edge that follows and compares them with an expectation it formed at the strobe edge from its own sample record, its mirror of the registers and the live mode value. The mirror is updated only after the expectation is formed, so a write at the same edge as a strobe is modelled as taking effect one bit later. Readback is combinational, so the bench checks it one nanosecond after it moves the read address in the low half of a cycle. At every other falling edge it confirms that `dout_valid` is low and `dout` has not moved.

// File: rtl/bds_pkg.sv
package bds_pkg;

   // quarter-bit phases per bit period
   localparam int unsigned QPB      = 4;
   // field bits that select the sampling phase in split mode
   localparam int unsigned PH_W     = 2;
   // default sampling point in combined mode, in quarter-bits
   localparam int unsigned LOW_BASE = 3;

   // history depth needed to reach the largest combined-mode delay
   function automatic int unsigned hist_depth(input int unsigned fw);
      return LOW_BASE + (1 << fw) - 1 + 2;
   endfunction

endpackage

// File: rtl/bds_regs.sv
module bds_regs
   import bds_pkg::*;
#(
   parameter int unsigned NS = 8,
   parameter int unsigned FW = 5,
   parameter int unsigned RW = 16,
   parameter int unsigned AW = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [RW-1:0]          wr_data,
   input  logic [AW-1:0]          rd_addr,
   output logic [RW-1:0]          rd_data,
   output logic [NS-1:0][FW-1:0]  fld_o
);

   logic [FW-1:0] fld_q [NS];

   for (genvar g = 0; g < NS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            fld_q[g] <= '0;
         else if (wr_en && (int'(wr_addr) == g))
            fld_q[g] <= wr_data[FW-1:0];
      end
      assign fld_o[g] = fld_q[g];
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) < NS)
         rd_data[FW-1:0] = fld_q[rd_addr];
   end

   // R8
   wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) < NS)) |=> (fld_q[$past(wr_addr)] == $past(wr_data[FW-1:0])));

   // R2
   rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data >> FW) == '0);

endmodule

// File: rtl/bds_history.sv
module bds_history #(
   parameter int unsigned DEPTH = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [DEPTH-1:0] hist_o
);

   logic [DEPTH-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist_q <= '0;
      else
         hist_q <= {hist_q[DEPTH-2:0], din};
   end

   assign hist_o = hist_q;

endmodule

// File: rtl/bds_pick.sv
module bds_pick
   import bds_pkg::*;
#(
   parameter int unsigned FW    = 5,
   parameter int unsigned DEPTH = 36,
   parameter int unsigned TAP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             mode_hi,
   input  logic [FW-1:0]    fld,
   input  logic [DEPTH-1:0] hist,
   output logic             bit_o
);

   localparam int unsigned QSH = $clog2(QPB);
   localparam int unsigned DW  = TAP_W + 1;

   logic [DW-1:0] dq;
   logic [DW-1:0] tap;
   logic          bit_q;

   always_comb begin
      if (mode_hi)
         dq = DW'(fld[PH_W-1:0]) + DW'(1) + (DW'(fld[FW-1:PH_W]) << QSH);
      else
         dq = DW'(fld) + DW'(LOW_BASE);
      tap = DW'(DEPTH - 1) - dq;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bit_q <= 1'b0;
      else if (strobe)
         bit_q <= hist[tap[TAP_W-1:0]];
   end

   assign bit_o = bit_q;

   // R3
   tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> ((tap >= DW'(1)) && (tap <= DW'(DEPTH - 2))));

   // R7
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(bit_o));

endmodule

// File: rtl/bit_delay_sampler.sv
module bit_delay_sampler
   import bds_pkg::*;
#(
   parameter int unsigned NS = 8,
   parameter int unsigned FW = 5,
   parameter int unsigned RW = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bit_strobe,
   input  logic [NS-1:0]           din,
   input  logic                    mode_hi,
   input  logic                    wr_en,
   input  logic [$clog2(NS)-1:0]   wr_addr,
   input  logic [RW-1:0]           wr_data,
   input  logic [$clog2(NS)-1:0]   rd_addr,
   output logic [RW-1:0]           rd_data,
   output logic [NS-1:0]           dout,
   output logic                    dout_valid
);

   localparam int unsigned AW    = $clog2(NS);
   localparam int unsigned DEPTH = hist_depth(FW);
   localparam int unsigned TAP_W = $clog2(DEPTH);

   initial begin
      assert (NS >= 2) else $error("NS must be at least 2");
      assert (FW > PH_W) else $error("FW must exceed the phase width");
      assert (RW >= FW) else $error("RW must hold the field");
      assert (QPB == (1 << PH_W)) else $error("phase field must cover one bit");
   end

   logic [NS-1:0][FW-1:0] fld;
   logic                  valid_q;

   bds_regs #(.NS(NS), .FW(FW), .RW(RW), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .fld_o   (fld)
   );

   for (genvar s = 0; s < NS; s++) begin : g_line
      logic [DEPTH-1:0] hist;

      bds_history #(.DEPTH(DEPTH)) u_hist (
         .clk    (clk),
         .rst_n  (rst_n),
         .din    (din[s]),
         .hist_o (hist)
      );

      bds_pick #(.FW(FW), .DEPTH(DEPTH), .TAP_W(TAP_W)) u_pick (
         .clk     (clk),
         .rst_n   (rst_n),
         .strobe  (bit_strobe),
         .mode_hi (mode_hi),
         .fld     (fld[s]),
         .hist    (hist),
         .bit_o   (dout[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         valid_q <= 1'b0;
      else
         valid_q <= bit_strobe;
   end

   assign dout_valid = valid_q;

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> dout_valid);

   // R7
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> $past(bit_strobe));

endmodule

// File: tb/bit_delay_sampler_bench.sv
`timescale 1ns/1ps
module bit_delay_sampler_bench;

   localparam int NS   = 8;
   localparam int WIN  = 36;
   localparam int CLKP = 20;
   localparam int NV   = 5;

   localparam logic        VMODE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [39:0] VFLD  [NV] = '{
      {5'd7,  5'd6,  5'd5,  5'd4,  5'd3,  5'd2,  5'd1,  5'd0},   // R3 spread
      {5'd19, 5'd12, 5'd24, 5'd16, 5'd8,  5'd19, 5'd30, 5'd31},  // R4 includes 19
      {5'd22, 5'd13, 5'd31, 5'd28, 5'd7,  5'd4,  5'd3,  5'd0},   // R5 split mode
      {5'd3,  5'd0,  5'd31, 5'd0,  5'd3,  5'd28, 5'd31, 5'd0},   // R6 extremes
      {5'd19, 5'd19, 5'd19, 5'd19, 5'd19, 5'd19, 5'd19, 5'd19}   // R4 all lines
   };
   localparam int VTAG [NV] = '{3, 4, 5, 6, 4};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_strobe = 1'b0;
   logic [NS-1:0] din = '0;
   logic          mode_hi = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [15:0]   rd_data;
   logic [NS-1:0] dout;
   logic          dout_valid;

   int    total = 0;
   int    bad = 0;
   bit    run = 1'b0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R7";

   logic [NS-1:0] samp [4096];
   logic [4:0]    mirror [NS];
   logic [NS-1:0] exp_d = '0;
   logic [NS-1:0] last_d = '0;
   bit            pending = 1'b0;
   int            cyc = 0;
   logic [31:0]   lfsr = 32'h1ACE_B00C;

   bit_delay_sampler u_bit_delay_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_strobe (bit_strobe),
      .din        (din),
      .mode_hi    (mode_hi),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

   always #(CLKP/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic write_reg(input int a, input logic [15:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 3'(a);
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_chk(input int a, input logic [15:0] expv, input string req);
      rd_addr = 3'(a);
      #1;
      chk(req, 32'(rd_data), 32'(expv));
   endtask

   // model of the sampler, built from the requirements
   always @(posedge clk) begin
      if (rst_n) begin
         samp[cyc % 4096] = din;
         if (bit_strobe) begin
            for (int s = 0; s < NS; s++) begin
               int f;
               int d;
               int idx;
               f = int'(mirror[s]);
               d = mode_hi ? ((f % 4) + 1 + 4 * (f / 4)) : (3 + f);
               idx = cyc - WIN + d;
               exp_d[s] = (idx < 0) ? 1'b0 : samp[idx % 4096][s];
            end
            pending = 1'b1;
         end
         if (wr_en)
            mirror[wr_addr] = wr_data[4:0];
         cyc++;
      end
   end

   // line and strobe driver
   initial begin
      int ph;
      ph = 0;
      forever begin
         @(negedge clk);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         din = lfsr[7:0] ^ lfsr[23:16];
         if (run) begin
            ph = (ph + 1) % 4;
            bit_strobe = (ph == 0);
         end else begin
            bit_strobe = 1'b0;
         end
      end
   end

   // output checker
   initial begin
      forever begin
         @(negedge clk);
         if (chk_on) begin
            if (pending) begin
               chk(cur_req, 32'(dout), 32'(exp_d));
               chk("R7", 32'(dout_valid), 32'd1);
               last_d = exp_d;
               pending = 1'b0;
            end else begin
               chk("R7", {23'd0, dout_valid, dout}, {23'd0, 1'b0, last_d});
            end
         end
      end
   end

   initial begin
      #(CLKP * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < NS; s++) mirror[s] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      chk("R1", 32'(dout), 32'd0);
      chk("R1", 32'(dout_valid), 32'd0);
      for (int a = 0; a < NS; a++) read_chk(a, 16'h0000, "R1");

      // R2 upper bits never stored
      write_reg(2, 16'hFFFF);
      read_chk(2, 16'h001F, "R2");
      write_reg(2, 16'hA5A0);
      read_chk(2, 16'h0000, "R2");
      write_reg(5, 16'h5A33);
      read_chk(5, 16'h0013, "R2");
      read_chk(4, 16'h0000, "R2");

      run = 1'b1;

      for (int v = 0; v < NV; v++) begin
         case (VTAG[v])
            3: cur_req = "R3";
            4: cur_req = "R4";
            5: cur_req = "R5";
            default: cur_req = "R6";
         endcase
         @(negedge clk);
         mode_hi = VMODE[v];
         for (int s = 0; s < NS; s++)
            write_reg(s, {11'd0, VFLD[v][5*s +: 5]});
         for (int s = 0; s < NS; s++)
            read_chk(s, {11'd0, VFLD[v][5*s +: 5]}, cur_req);
         repeat (48) @(negedge clk);
      end

      // R8 write at the same edge as a strobe, one line only
      cur_req = "R8";
      @(negedge clk);
      mode_hi = 1'b0;
      @(negedge clk);
      #1;
      while (!bit_strobe) begin
         @(negedge clk);
         #1;
      end
      wr_en = 1'b1;
      wr_addr = 3'd0;
      wr_data = 16'h000A;
      @(negedge clk);
      wr_en = 1'b0;
      read_chk(0, 16'h000A, "R8");
      read_chk(1, 16'h0013, "R8");
      repeat (24) @(negedge clk);

      // R9 global mode changed between strobes
      cur_req = "R9";
      write_reg(3, 16'h0002);
      write_reg(6, 16'h001D);
      repeat (40) begin
         @(negedge clk);
         mode_hi = lfsr[9];
      end
      repeat (8) @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule